// File: doc/BRIEF.md
# Register Rename Status Table

This block holds the architectural floating-point register file of an out-of-order issue stage. Alongside each register it keeps a pending-producer tag. The tag names the scheduling slot that will produce the register's next value. A tag of zero means no write is outstanding. When an instruction issues, the table is read through two source ports. A source with no pending writer returns its stored value. A source with a pending writer returns the producer tag instead, so the waiting operand can pick up the result later.

In the same issue cycle, the destination register is claimed by the issuing slot's tag. This renames the register. Results arrive on a tagged broadcast bus. A register takes the broadcast data only when the broadcast tag equals its recorded producer tag. Once a newer writer has claimed a register, any result from an older producer of that register is simply dropped, which removes write-after-write hazards. A source read whose pending tag is on the bus in that same cycle is bypassed, so it receives the result directly.

Top module: `rename_table`

## Requirements
- R1: After a synchronous active-low reset, every register value is zero and every pending tag is zero, so every source read returns value 0 and tag 0.
- R2: A source read of a register whose pending tag is zero returns the stored value and tag 0 in the same cycle, with no clock edge in between.
- R3: A source read of a register whose pending tag is nonzero, and which is not bypassed, returns that tag with the value output forced to zero.
- R4: An issue with `issue_valid` high and a nonzero `issue_tag` writes that tag into the status of `issue_dst` at the next clock edge. Source reads in the issuing cycle still see the status as it was before that edge.
- R5: A broadcast with `res_valid` high and a tag equal to a register's nonzero status writes `res_data` into that register and clears its status to zero at the same edge.
- R6: A broadcast whose tag differs from a register's status leaves that register's value and status unchanged. This holds in particular when the register has since been renamed to a newer producer.
- R7: If a register is renamed in the same cycle as a broadcast that matches its current status, the new tag is recorded and the register's value is not written.
- R8: A source read whose register status equals the tag of a valid broadcast in the same cycle returns `res_data` with tag 0.
- R9: An issue with `issue_valid` low, or with `issue_tag` equal to zero, changes no status.
- R10: With `res_valid` low, nothing is written or bypassed, whatever the value of `res_tag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue_valid | input | 1 | An instruction issues this cycle |
| issue_src_a | input | 2 | First source register index |
| issue_src_b | input | 2 | Second source register index |
| issue_dst | input | 2 | Destination register index |
| issue_tag | input | 4 | Tag of the issuing slot (zero means no rename) |
| res_valid | input | 1 | A result is being broadcast |
| res_tag | input | 4 | Tag of the producer of the broadcast result |
| res_data | input | 64 | Broadcast result data |
| src_a_val | output | 64 | First source value (zero when a tag is returned) |
| src_a_tag | output | 4 | First source producer tag (zero when the value is valid) |
| src_b_val | output | 64 | Second source value (zero when a tag is returned) |
| src_b_tag | output | 4 | Second source producer tag (zero when the value is valid) |

## Verification
The table's state is observed only through the two source ports, which are combinational. A wrong status or value therefore shows up as a wrong value or tag on the very next read of that register. Usually this is the cycle right after the faulty edge. A lost clear shows as a stale tag. A dropped or wrongly accepted write shows as a wrong value, or as a tag in place of a value. A faulty bypass shows as a tag in the cycle the broadcast is on the bus. The bench reads both ports every cycle, while a behavioural model tracks values and tags, so a fault is caught no later than the next cycle that reads the affected register.

// File: rtl/rename_pkg.sv
// Package: default sizing shared by the rename table and its sub-blocks.
// Assumes: tag value zero is reserved to mean "no pending writer".
package rename_pkg;
    localparam int DEF_REGS  = 4;
    localparam int DEF_DATA  = 64;
    localparam int DEF_TAG   = 4;
    localparam logic [DEF_TAG-1:0] NO_TAG = '0;
endpackage

// File: rtl/rename_entry.sv
// Module: one register of the table: a data value and a pending-producer tag.
// Does: takes a new tag on rename; on a tag-matched broadcast takes the data
//       and clears its tag, unless a rename happens in that cycle.
// Assumes: rename_en is already decoded for this register and implies a
//          nonzero new_tag.
module rename_entry #(
    parameter int DW = 64,
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rename_en,
    input  logic [TW-1:0] new_tag,
    input  logic          bus_valid,
    input  logic [TW-1:0] bus_tag,
    input  logic [DW-1:0] bus_data,
    output logic [DW-1:0] val_q,
    output logic [TW-1:0] tag_q
);
    logic bus_hit;

    // Broadcast match: a write is pending and the bus carries its producer.
    always_comb bus_hit = bus_valid && (tag_q != '0) && (tag_q == bus_tag);

    // State update: rename has priority, otherwise a matched result lands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val_q <= '0;
            tag_q <= '0;
        end else if (rename_en) begin
            tag_q <= new_tag;
        end else if (bus_hit) begin
            val_q <= bus_data;
            tag_q <= '0;
        end
    end

    // R4
    rename_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rename_en |=> tag_q == $past(new_tag));
    // R5
    result_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_hit && !rename_en) |=> (tag_q == '0) && (val_q == $past(bus_data)));
    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_hit && !rename_en) |=> $stable(tag_q) && $stable(val_q));
    // R7
    collide_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_hit && rename_en) |=> $stable(val_q));
endmodule

// File: rtl/rename_read_port.sv
// Module: one source read port of the table with result-bus bypass.
// Does: picks a register; returns its value if no write is pending, the bus
//       data if its producer is broadcasting now, else its producer tag.
// Assumes: status zero means the stored value is current.
module rename_read_port #(
    parameter int NREG = 4,
    parameter int DW   = 64,
    parameter int TW   = 4,
    localparam int IW  = $clog2(NREG)
) (
    input  logic [IW-1:0]          sel,
    input  logic [NREG-1:0][DW-1:0] vals,
    input  logic [NREG-1:0][TW-1:0] tags,
    input  logic                   bus_valid,
    input  logic [TW-1:0]          bus_tag,
    input  logic [DW-1:0]          bus_data,
    output logic [DW-1:0]          out_val,
    output logic [TW-1:0]          out_tag
);
    logic [DW-1:0] cur_val;
    logic [TW-1:0] cur_tag;

    // Register select.
    always_comb begin
        cur_val = vals[sel];
        cur_tag = tags[sel];
    end

    // Value, bypass or tag selection.
    always_comb begin
        if (cur_tag == '0) begin
            out_val = cur_val;
            out_tag = '0;
        end else if (bus_valid && (bus_tag == cur_tag)) begin
            out_val = bus_data;
            out_tag = '0;
        end else begin
            out_val = '0;
            out_tag = cur_tag;
        end
    end
endmodule

// File: rtl/rename_table.sv
// Module: register rename status table (top).
// Does: holds NREG data registers with producer tags, serves two source
//       reads per issue, renames the destination, and absorbs tagged results.
// Assumes: at most one issue and one broadcast per cycle; tag zero is blank.
module rename_table #(
    parameter int NREG = rename_pkg::DEF_REGS,
    parameter int DW   = rename_pkg::DEF_DATA,
    parameter int TW   = rename_pkg::DEF_TAG,
    localparam int IW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          issue_valid,
    input  logic [IW-1:0] issue_src_a,
    input  logic [IW-1:0] issue_src_b,
    input  logic [IW-1:0] issue_dst,
    input  logic [TW-1:0] issue_tag,
    input  logic          res_valid,
    input  logic [TW-1:0] res_tag,
    input  logic [DW-1:0] res_data,
    output logic [DW-1:0] src_a_val,
    output logic [TW-1:0] src_a_tag,
    output logic [DW-1:0] src_b_val,
    output logic [TW-1:0] src_b_tag
);
    logic [NREG-1:0][DW-1:0] reg_val;
    logic [NREG-1:0][TW-1:0] reg_tag;
    logic [NREG-1:0]         ren_dec;

    // Destination decode: one-hot rename strobe, blank tags rename nothing.
    always_comb begin
        ren_dec = '0;
        if (issue_valid && (issue_tag != rename_pkg::NO_TAG[TW-1:0]))
            ren_dec[issue_dst] = 1'b1;
    end

    for (genvar g = 0; g < NREG; g++) begin : g_entry
        rename_entry #(.DW(DW), .TW(TW)) i_entry (
            .clk       (clk),
            .rst_n     (rst_n),
            .rename_en (ren_dec[g]),
            .new_tag   (issue_tag),
            .bus_valid (res_valid),
            .bus_tag   (res_tag),
            .bus_data  (res_data),
            .val_q     (reg_val[g]),
            .tag_q     (reg_tag[g])
        );
    end

    rename_read_port #(.NREG(NREG), .DW(DW), .TW(TW)) i_port_a (
        .sel (issue_src_a), .vals (reg_val), .tags (reg_tag),
        .bus_valid (res_valid), .bus_tag (res_tag), .bus_data (res_data),
        .out_val (src_a_val), .out_tag (src_a_tag)
    );

    rename_read_port #(.NREG(NREG), .DW(DW), .TW(TW)) i_port_b (
        .sel (issue_src_b), .vals (reg_val), .tags (reg_tag),
        .bus_valid (res_valid), .bus_tag (res_tag), .bus_data (res_data),
        .out_val (src_b_val), .out_tag (src_b_tag)
    );

    // R8
    bypass_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_tag != '0) |-> src_a_tag != res_tag);
    // R8
    bypass_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_tag != '0) |-> src_b_tag != res_tag);
    // R3
    tag_zero_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src_a_tag != '0) |-> src_a_val == '0);
    // R9
    no_rename_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!issue_valid || issue_tag == '0) |-> $onehot0(ren_dec) && ren_dec == '0);
endmodule

// File: tb/test_rename_table.sv
// Bench: behavioural model of values and tags, compared on both read ports
// every cycle during directed and pseudo-random stimulus.
module test_rename_table;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_valid = 1'b0;
    logic [1:0]  issue_src_a = '0, issue_src_b = '0, issue_dst = '0;
    logic [3:0]  issue_tag = '0;
    logic        res_valid = 1'b0;
    logic [3:0]  res_tag = '0;
    logic [63:0] res_data = '0;
    logic [63:0] src_a_val, src_b_val;
    logic [3:0]  src_a_tag, src_b_tag;

    int total = 0;
    int bad = 0;
    logic [63:0] m_val [4];
    logic [3:0]  m_tag [4];
    int unsigned seed = 32'h1234_5678;

    always #4 clk = ~clk;

    rename_table i_rename_table (
        .clk, .rst_n, .issue_valid, .issue_src_a, .issue_src_b, .issue_dst,
        .issue_tag, .res_valid, .res_tag, .res_data,
        .src_a_val, .src_a_tag, .src_b_val, .src_b_tag
    );

    function automatic int unsigned rnd();
        seed ^= seed << 13;
        seed ^= seed >> 17;
        seed ^= seed << 5;
        return seed;
    endfunction

    task automatic check_port(input string req, input string port, input logic [1:0] r,
                              input logic [63:0] got_v, input logic [3:0] got_t);
        logic [63:0] ev;
        logic [3:0]  et;
        string       kind;
        if (m_tag[r] == 4'd0) begin ev = m_val[r]; et = 4'd0; kind = "R2"; end
        else if (res_valid && res_tag == m_tag[r]) begin ev = res_data; et = 4'd0; kind = "R8"; end
        else begin ev = '0; et = m_tag[r]; kind = "R3"; end
        total++;
        if (got_v !== ev || got_t !== et) begin
            bad++;
            $display("FAIL %s/%s port %s reg %0d: got val=%h tag=%0d exp val=%h tag=%0d",
                     req, kind, port, r, got_v, got_t, ev, et);
        end
    endtask

    // One cycle: drive at negedge, check reads, update model at posedge.
    task automatic step(input string req, input logic iv, input logic [1:0] sa,
                        input logic [1:0] sb, input logic [1:0] d, input logic [3:0] it,
                        input logic bv, input logic [3:0] bt, input logic [63:0] bd);
        issue_valid = iv; issue_src_a = sa; issue_src_b = sb; issue_dst = d;
        issue_tag = it; res_valid = bv; res_tag = bt; res_data = bd;
        #1;
        check_port(req, "a", sa, src_a_val, src_a_tag);
        check_port(req, "b", sb, src_b_val, src_b_tag);
        @(posedge clk);
        for (int i = 0; i < 4; i++) begin
            if (iv && it != 4'd0 && d == i[1:0]) m_tag[i] = it;
            else if (bv && m_tag[i] != 4'd0 && m_tag[i] == bt) begin
                m_val[i] = bd; m_tag[i] = 4'd0;
            end
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) begin m_val[i] = '0; m_tag[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state on all registers
        step("R1", 0, 0, 1, 0, 0, 0, 0, 0);
        step("R1", 0, 2, 3, 0, 0, 0, 0, 0);
        // R4: rename reg0 to tag 3; same-cycle read still sees old status
        step("R4", 1, 0, 0, 0, 4'd3, 0, 0, 0);
        step("R4", 0, 0, 1, 0, 0, 0, 0, 0);
        // R6: newer writer tag 5 claims reg0, stale tag-3 result is dropped
        step("R6", 1, 0, 1, 0, 4'd5, 0, 0, 0);
        step("R6", 0, 0, 1, 0, 0, 1, 4'd3, 64'hDEAD_0003);
        step("R6", 0, 0, 0, 0, 0, 0, 0, 0);
        // R8 and R5: bypass of tag 5 then value landed
        step("R8", 0, 0, 2, 0, 0, 1, 4'd5, 64'h5555_AAAA_0000_0005);
        step("R5", 0, 0, 0, 0, 0, 0, 0, 0);
        // R7: rename reg1 while its old producer broadcasts
        step("R7", 1, 1, 0, 1, 4'd7, 0, 0, 0);
        step("R7", 1, 1, 1, 1, 4'd8, 1, 4'd7, 64'h7777);
        step("R7", 0, 1, 0, 0, 0, 0, 0, 0);
        step("R5", 0, 2, 3, 0, 0, 1, 4'd8, 64'h8888_8888);
        step("R5", 0, 1, 1, 0, 0, 0, 0, 0);
        // R9: blank tag and invalid issue rename nothing
        step("R9", 1, 2, 2, 2, 4'd0, 0, 0, 0);
        step("R9", 0, 2, 2, 2, 4'd4, 0, 0, 0);
        step("R9", 0, 2, 3, 0, 0, 0, 0, 0);
        // R10: invalid bus with a matching tag does nothing
        step("R10", 1, 3, 3, 3, 4'd9, 0, 0, 0);
        step("R10", 0, 3, 3, 0, 0, 0, 4'd9, 64'hBAD);
        step("R10", 0, 3, 2, 0, 0, 1, 4'd9, 64'h9999);
        step("R5", 0, 3, 0, 0, 0, 0, 0, 0);
        // Mixed traffic: R2 R3 R4 R5 R6 R7 R8 all exercised
        for (int n = 0; n < 4000; n++) begin
            logic [3:0] bt;
            int unsigned x;
            x = rnd();
            bt = (x[3:2] == 2'b00) ? rnd() % 10 : m_tag[rnd() % 4];
            step("random", x[4], x[6:5], x[8:7], x[10:9], 4'(x[15:12] % 10),
                 x[16] | x[17], bt, {rnd(), rnd()});
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule